// File: doc/BRIEF.md
# Hot-Standby Channel Role Controller

This block decides the role of each of the two channels of a duplicated safety computer. Each channel steps through six roles: unpowered, starting, following, host, standby and fault. Exactly one channel at a time may be host and drive results to the outside world. The other channel tracks it as a standby. To become standby, a channel must first run a following phase, in which it catches up on the host's history. That phase must finish inside a bounded time.

When the host reports a fault while its partner is standby, the partner takes over as host on the same clock edge. A channel that keeps failing is shut down. On its fourth failure it is forced to the unpowered state, and its power-off command stays latched until a maintenance clear. A millisecond tick input drives the start and following deadlines. A degraded flag tells the system that only one channel is carrying the load.

All inputs are plain level or strobe controls sampled on the rising clock edge. There is no data stream, so there is no valid/ready handshake and no back-pressure. Index 0 of every two-bit input and of `pwr_off` belongs to channel A, and index 1 belongs to channel B.

Top module: `hsb_role_ctrl`

## Requirements
- R1: After reset both channels are unpowered (code 0), `degraded` is 0 and `pwr_off` is 0. The role codes are: unpowered 0, starting 1, following 2, host 3, standby 4, fault 5.
- R2: An unpowered channel with its power-off latch clear moves to starting on the edge after its power-up request.
- R3: A starting channel that sees self-test-ok becomes host if the partner is not host and is not becoming host on that edge; otherwise it moves to following. If both channels finish starting on the same edge and no host exists, channel A becomes host and channel B goes to following.
- R4: A following channel enters standby on the edge after its follow-done strobe. Standby is never entered from any other role.
- R5: A following channel that sees 400 tick pulses without follow-done returns to starting on the edge of the 400th tick.
- R6: A starting channel that sees 400 tick pulses without self-test-ok goes to fault on the edge of the 400th tick, and this counts as a failure.
- R7: The two channels are never host at the same time.
- R8: When the host reports a fault while the partner is standby, on the same edge the host goes to fault and the partner becomes host.
- R9: A channel in fault that sees self-test-ok moves to following, never directly to standby or host.
- R10: A fault report while a channel is starting, following, host or standby counts as a failure. The fourth failure sends that channel to unpowered and sets its `pwr_off` bit. While that bit is set, power-up requests are ignored.
- R11: A maintenance clear on a channel clears its `pwr_off` bit and its failure count on the next edge, so a later fault leads to fault rather than power-off.
- R12: `degraded` is 1 exactly when one channel is host and the other is in fault, following or unpowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| pwr_req | input | 2 | Power-up request per channel |
| selftest_ok | input | 2 | Start-up or recovery self-test passed |
| follow_done | input | 2 | History catch-up finished strobe |
| fault | input | 2 | Fault report per channel |
| maint_clr | input | 2 | Maintenance clear of failure count and power-off latch |
| state_a | output | 3 | Role code of channel A |
| state_b | output | 3 | Role code of channel B |
| degraded | output | 1 | Only one channel is carrying the load |
| pwr_off | output | 2 | Latched power-off command per channel |

## Verification
Every role change and every `pwr_off` change is due on the first rising edge after the input that causes it. `degraded` is decoded from the role registers, so it changes in that same cycle. The deadline transitions land on the edge that carries the 400th tick after the role was entered. The bench checks every one of the 399 cycles before that edge and then the transition itself. The driver queues the expected roles right after the edge that should produce them. The monitor compares them on the following falling edge, so every sample is one register stage after its stimulus and clear of the active edge.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [2:0] {
    ROLE_OFF     = 3'd0,
    ROLE_START   = 3'd1,
    ROLE_FOLLOW  = 3'd2,
    ROLE_HOST    = 3'd3,
    ROLE_STANDBY = 3'd4,
    ROLE_FAULT   = 3'd5
  } role_t;
endpackage

// File: rtl/hsb_deadline.sv
module hsb_deadline #(
  parameter int LIMIT = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt;

  assign expired = run && tick && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !run) cnt <= '0;
    else if (tick)                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsb_fail_tracker.sv
module hsb_fail_tracker #(
  parameter int MAX_FAIL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic clear,
  output logic at_limit
);
  localparam int FW = $clog2(MAX_FAIL + 1);
  logic [FW-1:0] cnt;

  assign at_limit = (cnt == FW'(MAX_FAIL));

  always_ff @(posedge clk) begin
    if (!rst_n || clear)         cnt <= '0;
    else if (bump && !at_limit)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hsb_channel.sv
module hsb_channel
  import hsb_pkg::*;
#(
  parameter int TIMEOUT_MS = 400,
  parameter int MAX_FAIL   = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_ms,
  input  logic  pwr_req,
  input  logic  selftest_ok,
  input  logic  follow_done,
  input  logic  fault,
  input  logic  maint_clr,
  input  logic  may_host,
  input  logic  peer_host_fault,
  output role_t role,
  output logic  take_host,
  output logic  off_latched
);
  role_t role_nxt;
  logic  expired, at_limit, fail_evt, bump, set_latch;

  hsb_deadline #(.LIMIT(TIMEOUT_MS)) u_deadline (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (role == ROLE_START || role == ROLE_FOLLOW),
    .restart (role_nxt != role),
    .tick    (tick_ms),
    .expired (expired)
  );

  hsb_fail_tracker #(.MAX_FAIL(MAX_FAIL)) u_fails (
    .clk      (clk),
    .rst_n    (rst_n),
    .bump     (bump),
    .clear    (maint_clr),
    .at_limit (at_limit)
  );

  always_comb begin
    unique case (role)
      ROLE_START:                        fail_evt = fault || expired;
      ROLE_FOLLOW, ROLE_HOST,
      ROLE_STANDBY:                      fail_evt = fault;
      default:                           fail_evt = 1'b0;
    endcase
  end

  assign take_host = (role == ROLE_START) && selftest_ok && !fail_evt && may_host;

  always_comb begin
    role_nxt  = role;
    bump      = 1'b0;
    set_latch = 1'b0;
    unique case (role)
      ROLE_OFF:     if (pwr_req && !off_latched) role_nxt = ROLE_START;
      ROLE_START:   if (selftest_ok) role_nxt = may_host ? ROLE_HOST : ROLE_FOLLOW;
      ROLE_FOLLOW:  if (follow_done) role_nxt = ROLE_STANDBY;
                    else if (expired) role_nxt = ROLE_START;
      ROLE_STANDBY: if (peer_host_fault) role_nxt = ROLE_HOST;
      ROLE_FAULT:   if (selftest_ok) role_nxt = ROLE_FOLLOW;
      default:      role_nxt = role;
    endcase
    if (fail_evt) begin
      if (at_limit) begin
        role_nxt  = ROLE_OFF;
        set_latch = 1'b1;
      end else begin
        role_nxt  = ROLE_FAULT;
        bump      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role        <= ROLE_OFF;
      off_latched <= 1'b0;
    end else begin
      role <= role_nxt;
      if (maint_clr)      off_latched <= 1'b0;
      else if (set_latch) off_latched <= 1'b1;
    end
  end
endmodule

// File: rtl/hsb_role_ctrl.sv
module hsb_role_ctrl
  import hsb_pkg::*;
#(
  parameter int TIMEOUT_MS = 400,
  parameter int MAX_FAIL   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic [1:0] pwr_req,
  input  logic [1:0] selftest_ok,
  input  logic [1:0] follow_done,
  input  logic [1:0] fault,
  input  logic [1:0] maint_clr,
  output logic [2:0] state_a,
  output logic [2:0] state_b,
  output logic       degraded,
  output logic [1:0] pwr_off
);
  localparam int NCH = 2;

  role_t            role [NCH];
  logic [NCH-1:0]   take, may, peer_fail, is_host, is_weak;

  // Channel A (index 0) wins a simultaneous claim; B may claim only when A does not.
  assign may[0] = !is_host[1];
  assign may[1] = !is_host[0] && !take[0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int PEER = NCH - 1 - i;
    assign is_host[i]   = (role[i] == ROLE_HOST);
    assign is_weak[i]   = (role[i] == ROLE_FAULT) || (role[i] == ROLE_FOLLOW) ||
                          (role[i] == ROLE_OFF);
    assign peer_fail[i] = is_host[PEER] && fault[PEER];

    hsb_channel #(.TIMEOUT_MS(TIMEOUT_MS), .MAX_FAIL(MAX_FAIL)) u_ch (
      .clk             (clk),
      .rst_n           (rst_n),
      .tick_ms         (tick_ms),
      .pwr_req         (pwr_req[i]),
      .selftest_ok     (selftest_ok[i]),
      .follow_done     (follow_done[i]),
      .fault           (fault[i]),
      .maint_clr       (maint_clr[i]),
      .may_host        (may[i]),
      .peer_host_fault (peer_fail[i]),
      .role            (role[i]),
      .take_host       (take[i]),
      .off_latched     (pwr_off[i])
    );
  end

  assign state_a  = role[0];
  assign state_b  = role[1];
  assign degraded = (is_host[0] && is_weak[1]) || (is_host[1] && is_weak[0]);
endmodule

// File: rtl/hsb_role_chk.sv
module hsb_role_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwr_req,
  input logic [1:0] fault,
  input logic [1:0] maint_clr,
  input logic [2:0] state_a,
  input logic [2:0] state_b,
  input logic       degraded,
  input logic [1:0] pwr_off
);
  p_single_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_a == 3'd3 && state_b == 3'd3));

  p_promote_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_a == 3'd4 && state_b == 3'd3 && fault[1] && !fault[0]) |=> state_a == 3'd3);

  p_promote_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_b == 3'd4 && state_a == 3'd3 && fault[0] && !fault[1]) |=> state_b == 3'd3);

  p_standby_entry_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_a != 3'd4) |=> (state_a == 3'd4) -> ($past(state_a) == 3'd2));

  p_standby_entry_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_b != 3'd4) |=> (state_b == 3'd4) -> ($past(state_b) == 3'd2));

  p_powerup_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_a == 3'd0 && pwr_req[0] && !pwr_off[0]) |=> state_a == 3'd1);

  p_latch_hold_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off[0] && !maint_clr[0]) |=> (state_a == 3'd0 && pwr_off[0]));

  p_latch_hold_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off[1] && !maint_clr[1]) |=> (state_b == 3'd0 && pwr_off[1]));

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    maint_clr[1] |=> !pwr_off[1]);

  p_degraded_r12: assert property (@(posedge clk) disable iff (!rst_n)
    degraded |-> ((state_a == 3'd3) != (state_b == 3'd3)));
endmodule

bind hsb_role_ctrl hsb_role_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_req   (pwr_req),
  .fault     (fault),
  .maint_clr (maint_clr),
  .state_a   (state_a),
  .state_b   (state_b),
  .degraded  (degraded),
  .pwr_off   (pwr_off)
);

// File: tb/sim_hsb_role_ctrl.sv
module sim_hsb_role_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic [1:0] pwr_req = '0, selftest_ok = '0, follow_done = '0, fault = '0, maint_clr = '0;
  logic [2:0] state_a, state_b;
  logic       degraded;
  logic [1:0] pwr_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] ea;
    logic [2:0] eb;
    logic       dg;
    logic [1:0] off;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  hsb_role_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_req(pwr_req),
    .selftest_ok(selftest_ok), .follow_done(follow_done), .fault(fault),
    .maint_clr(maint_clr), .state_a(state_a), .state_b(state_b),
    .degraded(degraded), .pwr_off(pwr_off)
  );

  // Driver: the stimulus is already applied; queue the expectation for the next edge.
  task automatic cyc(input logic [2:0] ea, input logic [2:0] eb, input logic dg,
                     input logic [1:0] off, input string tag);
    exp_t e;
    @(posedge clk);
    e.ea = ea; e.eb = eb; e.dg = dg; e.off = off; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    pwr_req = '0; selftest_ok = '0; follow_done = '0; fault = '0; maint_clr = '0;
  endtask

  // Monitor: compare on the falling edge that follows the edge under test.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (state_a !== e.ea || state_b !== e.eb || degraded !== e.dg || pwr_off !== e.off) begin
        errors++;
        $display("FAIL %s: got a=%0d b=%0d deg=%0b off=%b, expected a=%0d b=%0d deg=%0b off=%b",
                 e.tag, state_a, state_b, degraded, pwr_off, e.ea, e.eb, e.dg, e.off);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 2'b00, "R1 reset state");

    pwr_req = 2'b11;       cyc(1, 1, 0, 2'b00, "R2 power-up to start");
    selftest_ok = 2'b11;   cyc(3, 2, 1, 2'b00, "R3 tie goes to A, R12 degraded");
    follow_done = 2'b10;   cyc(3, 4, 0, 2'b00, "R4 follow to standby");
    fault = 2'b01;         cyc(5, 3, 1, 2'b00, "R8 promotion, R7");
    selftest_ok = 2'b01;   cyc(2, 3, 1, 2'b00, "R9 fault to following");
    follow_done = 2'b01;   cyc(4, 3, 0, 2'b00, "R4 A standby");
    fault = 2'b10;         cyc(3, 5, 1, 2'b00, "R8 reverse promotion");
    selftest_ok = 2'b10;   cyc(3, 2, 1, 2'b00, "R9 B following");

    tick_ms = 1'b1;
    for (int k = 0; k < 399; k++) cyc(3, 2, 1, 2'b00, "R5 hold in following");
    cyc(3, 1, 0, 2'b00, "R5 following deadline to start");
    for (int k = 0; k < 399; k++) cyc(3, 1, 0, 2'b00, "R6 hold in start");
    cyc(3, 5, 1, 2'b00, "R6 start deadline to fault");
    tick_ms = 1'b0;

    selftest_ok = 2'b10;   cyc(3, 2, 1, 2'b00, "R9 recover");
    fault = 2'b10;         cyc(3, 5, 1, 2'b00, "R10 third failure");
    selftest_ok = 2'b10;   cyc(3, 2, 1, 2'b00, "R9 recover again");
    fault = 2'b10;         cyc(3, 0, 1, 2'b10, "R10 fourth failure powers off");
    pwr_req = 2'b10;       cyc(3, 0, 1, 2'b10, "R10 power-up ignored");
    maint_clr = 2'b10;     cyc(3, 0, 1, 2'b00, "R11 latch released");
    pwr_req = 2'b10;       cyc(3, 1, 0, 2'b00, "R2 restart after clear");
    selftest_ok = 2'b10;   cyc(3, 2, 1, 2'b00, "R3 peer host gives following, R7");
    fault = 2'b10;         cyc(3, 5, 1, 2'b00, "R11 counter cleared");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule